// File: doc/BRIEF.md
# Compare-Based Event Timer Channel

This block gives one processor core a set of three deadline timers: a physical channel, a hypervisor-physical channel and a virtual channel. All three watch a shared, free-running 64-bit system count that they only read. Each channel holds a 64-bit deadline, called the compare value. Its condition is met whenever the count it sees is at or past that deadline. When the channel is enabled and not masked, it drives its own level-sensitive interrupt line.

Software sets a deadline in one of two ways. It can write the compare value directly as an absolute time. It can also write a signed 32-bit relative delay, which the block adds to the current count. Reading the relative view gives the remaining distance to the deadline. The virtual channel sees the system count minus a programmable 64-bit offset. That offset count is used for its compare, for its relative writes and for its relative reads.

Registers sit on a simple word-addressed port. A write takes effect on the rising clock edge where `reg_wr` is high. Read data depends only on the address, with no clock delay. The address is split as `{slot[ADDR_W-1:2], reg[1:0]}`:
- Slots 0, 1 and 2 are the physical, hypervisor and virtual channels.
- Slot 3 holds the virtual offset.
- Within a channel slot, reg 0 is control, 1 is the low compare word, 2 is the high compare word and 3 is the relative view.

Top module: `cmp_evt_timer`

## Requirements
- R1: After reset, every channel's control register reads 0, all three interrupt lines are low, and the virtual offset reads 0. The compare values are not defined at reset.
- R2: Control register layout: bit 0 is enable, bit 1 is mask, and bit 2 is a read-only status. Writes to bit 2 and to bits above it have no effect, and those upper bits read as 0.
- R3: While enabled, status reads 1 exactly when the channel's count is greater than or equal to its compare value, using an unsigned compare over all 64 bits.
- R4: Status reads 0 while enable is 0, whatever the count.
- R5: A channel's interrupt is high exactly when enable is 1, mask is 0 and the condition is met. It follows the current count and registers with no latency, and it drops as soon as the channel is disabled, masked, or its compare value is moved past the count. No pending state is kept.
- R6: Reg 1 and reg 2 of a channel write and read back the low and high 32-bit halves of its compare value.
- R7: Writing reg 3 sets the compare value to the channel's count at the write edge plus the written value, sign-extended to 64 bits. The carry propagates into the high half.
- R8: Reading reg 3 returns the low 32 bits of (compare value minus the channel's count).
- R9: The virtual channel uses the system count minus the offset held in slot 3 (reg 1 low half, reg 2 high half) for its compare, its relative writes and its relative reads. The other channels use the raw system count.
- R10: Channels are independent: a write to one channel changes neither the registers nor the interrupt of another.
- R11: Unmapped addresses (slot 3 regs 0 and 3, and slots 4 to 7) read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | CNT_W | Shared monotonic system count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address {slot, reg} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_phys | output | 1 | Physical channel interrupt |
| irq_hyp | output | 1 | Hypervisor-physical channel interrupt |
| irq_virt | output | 1 | Virtual channel interrupt |

## Verification
Register writes land on the rising edge that samples `reg_wr`, so the bench deasserts the strobe at the next falling edge and only then reads or looks at the interrupts. Read data and the interrupt lines have no register between them and the count or the stored state. The bench therefore changes `sys_cnt` or the address at a falling edge and samples 2 ns later, in the same cycle. Relative writes hold `sys_cnt` steady across the write edge, so the expected compare value is a known sum.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NUM_CH    = 3;
   localparam int CH_PHYS   = 0;
   localparam int CH_HYP    = 1;
   localparam int CH_VIRT   = 2;
   localparam int SLOT_VOFF = 3;

   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_MASK_BIT = 1;
   localparam int CTL_STAT_BIT = 2;

   typedef enum logic [1:0] {
      RG_CTL  = 2'd0,
      RG_CLO  = 2'd1,
      RG_CHI  = 2'd2,
      RG_TVAL = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec import tmr_pkg::*; #(
   parameter int ADDR_W = 5,
   localparam int SLOT_W = ADDR_W - 2
)(
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   output logic [NUM_CH-1:0] wr_ctl,
   output logic [NUM_CH-1:0] wr_clo,
   output logic [NUM_CH-1:0] wr_chi,
   output logic [NUM_CH-1:0] wr_tv,
   output logic              wr_off_lo,
   output logic              wr_off_hi,
   output logic [SLOT_W-1:0] rd_slot,
   output reg_sel_e          rd_reg
);
   logic     off_hit;

   assign rd_slot = reg_addr[ADDR_W-1:2];
   assign rd_reg  = reg_sel_e'(reg_addr[1:0]);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit       = reg_wr && (rd_slot == SLOT_W'(g));
      assign wr_ctl[g] = hit && (rd_reg == RG_CTL);
      assign wr_clo[g] = hit && (rd_reg == RG_CLO);
      assign wr_chi[g] = hit && (rd_reg == RG_CHI);
      assign wr_tv[g]  = hit && (rd_reg == RG_TVAL);
   end

   assign off_hit   = reg_wr && (rd_slot == SLOT_W'(SLOT_VOFF));
   assign wr_off_lo = off_hit && (rd_reg == RG_CLO);
   assign wr_off_hi = off_hit && (rd_reg == RG_CHI);
endmodule

// File: rtl/tmr_voffset.sv
module tmr_voffset import tmr_pkg::*; #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  sys_cnt,
   input  reg_sel_e          rd_reg,
   output logic [CNT_W-1:0]  voff_o,
   output logic [CNT_W-1:0]  vcnt_o,
   output logic [DATA_W-1:0] rdata
);
   logic [CNT_W-1:0] off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
      end else begin
         if (wr_lo) off_q[DATA_W-1:0]     <= wdata;
         if (wr_hi) off_q[CNT_W-1:DATA_W] <= wdata;
      end
   end

   assign voff_o = off_q;
   assign vcnt_o = sys_cnt - off_q;

   always_comb begin
      unique case (rd_reg)
         RG_CLO:  rdata = off_q[DATA_W-1:0];
         RG_CHI:  rdata = off_q[CNT_W-1:DATA_W];
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wr_ctl,
   input  logic              wr_clo,
   input  logic              wr_chi,
   input  logic              wr_tv,
   input  logic [DATA_W-1:0] wdata,
   input  reg_sel_e          rd_reg,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              en_o,
   output logic              mask_o,
   output logic [CNT_W-1:0]  cval_o
);
   localparam int EXT_W = CNT_W - DATA_W;

   logic             en_q, mask_q;
   logic [CNT_W-1:0] cval_q;
   logic [CNT_W-1:0] tv_sext;
   logic             met, status;
   logic [DATA_W-1:0] tv_rd;

   assign tv_sext = {{EXT_W{wdata[DATA_W-1]}}, wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= 1'b0;
      end else if (wr_ctl) begin
         en_q   <= wdata[CTL_EN_BIT];
         mask_q <= wdata[CTL_MASK_BIT];
      end
   end

   // compare value: reset value is not part of the contract
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cval_q <= '1;
      end else if (wr_tv) begin
         cval_q <= cnt + tv_sext;
      end else begin
         if (wr_clo) cval_q[DATA_W-1:0]     <= wdata;
         if (wr_chi) cval_q[CNT_W-1:DATA_W] <= wdata;
      end
   end

   assign met    = (cnt >= cval_q);
   assign status = en_q && met;
   assign irq    = status && !mask_q;
   assign tv_rd  = cval_q[DATA_W-1:0] - cnt[DATA_W-1:0];

   always_comb begin
      rdata = '0;
      unique case (rd_reg)
         RG_CTL: begin
            rdata[CTL_EN_BIT]   = en_q;
            rdata[CTL_MASK_BIT] = mask_q;
            rdata[CTL_STAT_BIT] = status;
         end
         RG_CLO:  rdata = cval_q[DATA_W-1:0];
         RG_CHI:  rdata = cval_q[CNT_W-1:DATA_W];
         RG_TVAL: rdata = tv_rd;
      endcase
   end

   assign en_o   = en_q;
   assign mask_o = mask_q;
   assign cval_o = cval_q;
endmodule

// File: rtl/cmp_evt_timer.sv
module cmp_evt_timer import tmr_pkg::*; #(
   parameter int CNT_W   = 64,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter bit VIRT_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  sys_cnt,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_phys,
   output logic              irq_hyp,
   output logic              irq_virt
);
   localparam int SLOT_W = ADDR_W - 2;

   if (CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("cmp_evt_timer: CNT_W must be twice DATA_W");
   end
   if ((1 << SLOT_W) <= SLOT_VOFF) begin : g_bad_addr
      $error("cmp_evt_timer: ADDR_W too small for the slot map");
   end

   logic [NUM_CH-1:0] wr_ctl, wr_clo, wr_chi, wr_tv;
   logic              wr_off_lo, wr_off_hi;
   logic [SLOT_W-1:0] rd_slot;
   reg_sel_e          rd_reg;

   logic [CNT_W-1:0]  voff_q, vcnt;
   logic [DATA_W-1:0] voff_rd;
   logic [CNT_W-1:0]  cnt_eff [NUM_CH];
   logic [DATA_W-1:0] ch_rd   [NUM_CH];
   logic [CNT_W-1:0]  ch_cval [NUM_CH];
   logic [NUM_CH-1:0] ch_irq, ch_en, ch_mask;
   logic [CNT_W-1:0]  cval_phys;

   tmr_regdec #(.ADDR_W(ADDR_W)) i_dec (
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .wr_ctl    (wr_ctl),
      .wr_clo    (wr_clo),
      .wr_chi    (wr_chi),
      .wr_tv     (wr_tv),
      .wr_off_lo (wr_off_lo),
      .wr_off_hi (wr_off_hi),
      .rd_slot   (rd_slot),
      .rd_reg    (rd_reg)
   );

   if (VIRT_EN) begin : g_voff
      tmr_voffset #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_voff (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo   (wr_off_lo),
         .wr_hi   (wr_off_hi),
         .wdata   (reg_wdata),
         .sys_cnt (sys_cnt),
         .rd_reg  (rd_reg),
         .voff_o  (voff_q),
         .vcnt_o  (vcnt),
         .rdata   (voff_rd)
      );
   end else begin : g_no_voff
      assign voff_q  = '0;
      assign vcnt    = sys_cnt;
      assign voff_rd = '0;
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      if (g == CH_VIRT) begin : g_vsrc
         assign cnt_eff[g] = vcnt;
      end else begin : g_psrc
         assign cnt_eff[g] = sys_cnt;
      end

      tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .cnt    (cnt_eff[g]),
         .wr_ctl (wr_ctl[g]),
         .wr_clo (wr_clo[g]),
         .wr_chi (wr_chi[g]),
         .wr_tv  (wr_tv[g]),
         .wdata  (reg_wdata),
         .rd_reg (rd_reg),
         .rdata  (ch_rd[g]),
         .irq    (ch_irq[g]),
         .en_o   (ch_en[g]),
         .mask_o (ch_mask[g]),
         .cval_o (ch_cval[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_slot == SLOT_W'(i)) reg_rdata = ch_rd[i];
      end
      if (rd_slot == SLOT_W'(SLOT_VOFF)) reg_rdata = voff_rd;
   end

   assign cval_phys = ch_cval[CH_PHYS];
   assign irq_phys  = ch_irq[CH_PHYS];
   assign irq_hyp   = ch_irq[CH_HYP];
   assign irq_virt  = ch_irq[CH_VIRT];
endmodule

// File: rtl/cmp_evt_timer_chk.sv
module cmp_evt_timer_chk import tmr_pkg::*; #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  sys_cnt,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq_phys,
   input logic              irq_hyp,
   input logic              irq_virt,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] ch_mask,
   input logic [CNT_W-1:0]  cval_phys,
   input logic [CNT_W-1:0]  voff_q
);
   localparam logic [ADDR_W-1:0] A_PCTL = ADDR_W'(CH_PHYS * 4 + 0);
   localparam logic [ADDR_W-1:0] A_PTV  = ADDR_W'(CH_PHYS * 4 + 3);

   logic [CNT_W-1:0]  tv_target;
   logic [NUM_CH-1:0] irq_vec;
   assign tv_target = sys_cnt + {{(CNT_W-DATA_W){reg_wdata[DATA_W-1]}}, reg_wdata};
   assign irq_vec   = {irq_virt, irq_hyp, irq_phys};

   p_rst_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ch_en == '0 && ch_mask == '0 && voff_q == '0));

   p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ($stable(ch_en) && $stable(ch_mask)));

   p_cval_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(cval_phys));

   p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vec & ~(ch_en & ~ch_mask)) == '0);

   p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_PCTL && !reg_wdata[CTL_EN_BIT]) |=> !irq_phys);

   p_tval_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_PTV) |=> (cval_phys == $past(tv_target)));

   p_voff_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(voff_q));
endmodule

bind cmp_evt_timer cmp_evt_timer_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sys_cnt   (sys_cnt),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_phys  (irq_phys),
   .irq_hyp   (irq_hyp),
   .irq_virt  (irq_virt),
   .ch_en     (ch_en),
   .ch_mask   (ch_mask),
   .cval_phys (cval_phys),
   .voff_q    (voff_q)
);

// File: tb/test_cmp_evt_timer.sv
`timescale 1ns/1ps
module test_cmp_evt_timer;
   localparam int CNT_W = 64, DATA_W = 32, ADDR_W = 5;
   localparam logic [4:0] A_P_CTL = 0,  A_P_CLO = 1,  A_P_CHI = 2,  A_P_TV = 3;
   localparam logic [4:0] A_H_CTL = 4,  A_H_CLO = 5,  A_H_CHI = 6;
   localparam logic [4:0] A_V_CTL = 8,  A_V_CLO = 9,  A_V_CHI = 10, A_V_TV = 11;
   localparam logic [4:0] A_O_R0 = 12, A_O_LO = 13, A_O_HI = 14, A_O_R3 = 15;
   localparam logic [4:0] A_BAD  = 21;

   logic              clk = 0;
   logic              rst_n = 0;
   logic [CNT_W-1:0]  sys_cnt = '0;
   logic              reg_wr = 0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq_phys, irq_hyp, irq_virt;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cmp_evt_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cmp_evt_timer (
      .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_phys(irq_phys), .irq_hyp(irq_hyp), .irq_virt(irq_virt));

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      #2;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      reg_addr = a;
      #2;
      check(tag, reg_rdata, exp);
   endtask

   task automatic set_cnt(input logic [63:0] v);
      @(negedge clk);
      sys_cnt = v;
      #2;
   endtask

   task automatic irq_chk(input string tag, input logic [2:0] exp);
      check(tag, {irq_virt, irq_hyp, irq_phys}, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 phys ctl", A_P_CTL, 0);
      rd_chk("R1 hyp ctl",  A_H_CTL, 0);
      rd_chk("R1 virt ctl", A_V_CTL, 0);
      rd_chk("R1 voff lo",  A_O_LO, 0);
      rd_chk("R1 voff hi",  A_O_HI, 0);
      irq_chk("R1 irqs", 3'b000);
   endtask

   task automatic t_ctl_fields;
      set_cnt(0);
      wr(A_P_CHI, 32'hFFFF_FFFF);
      wr(A_P_CLO, 32'hFFFF_FFFF);
      wr(A_P_CTL, 32'h7);
      rd_chk("R2 status bit ignored", A_P_CTL, 32'h3);
      wr(A_P_CTL, 32'hFFFF_FFFC);
      rd_chk("R2 upper bits ignored", A_P_CTL, 32'h0);
      wr(A_P_CTL, 32'hFFFF_FFF9);
      rd_chk("R2 enable only", A_P_CTL, 32'h1);
      irq_chk("R3 far deadline no irq", 3'b000);
      wr(A_P_CTL, 0);
   endtask

   task automatic t_compare;
      set_cnt(1000);
      wr(A_P_CHI, 0);
      wr(A_P_CLO, 1005);
      wr(A_P_CTL, 1);
      irq_chk("R5 before deadline", 3'b000);
      rd_chk("R3 status clear", A_P_CTL, 32'h1);
      set_cnt(1004);
      irq_chk("R3 one short", 3'b000);
      set_cnt(1005);
      irq_chk("R3 equal fires", 3'b001);
      rd_chk("R3 status at equal", A_P_CTL, 32'h5);
      set_cnt(1006);
      irq_chk("R3 past fires", 3'b001);
   endtask

   task automatic t_gating;
      wr(A_P_CTL, 3);
      irq_chk("R5 masked", 3'b000);
      rd_chk("R5 status while masked", A_P_CTL, 32'h7);
      wr(A_P_CTL, 0);
      irq_chk("R5 disabled", 3'b000);
      rd_chk("R4 status hidden when disabled", A_P_CTL, 32'h0);
      wr(A_P_CTL, 1);
      irq_chk("R5 re-enabled", 3'b001);
      wr(A_P_CLO, 2000);
      irq_chk("R5 deadline moved out", 3'b000);
      wr(A_P_CTL, 0);
   endtask

   task automatic t_wide;
      wr(A_P_CHI, 1);
      wr(A_P_CLO, 0);
      wr(A_P_CTL, 1);
      rd_chk("R6 hi readback", A_P_CHI, 1);
      rd_chk("R6 lo readback", A_P_CLO, 0);
      set_cnt(64'h0000_0000_FFFF_FFFF);
      irq_chk("R3 high half compared", 3'b000);
      set_cnt(64'h0000_0001_0000_0000);
      irq_chk("R3 reaches 64-bit deadline", 3'b001);
      wr(A_P_CTL, 0);
   endtask

   task automatic t_tval;
      set_cnt(5000);
      wr(A_P_TV, 100);
      rd_chk("R7 relative lo", A_P_CLO, 5100);
      rd_chk("R7 relative hi", A_P_CHI, 0);
      rd_chk("R8 remaining", A_P_TV, 100);
      wr(A_P_CTL, 1);
      set_cnt(5099);
      irq_chk("R7 one short", 3'b000);
      rd_chk("R8 remaining one", A_P_TV, 1);
      set_cnt(5100);
      irq_chk("R7 relative deadline", 3'b001);
      rd_chk("R8 remaining zero", A_P_TV, 0);
      set_cnt(5200);
      wr(A_P_TV, 32'hFFFF_FFF6);
      rd_chk("R7 negative offset", A_P_CLO, 5190);
      irq_chk("R7 past deadline fires", 3'b001);
      rd_chk("R8 negative remaining", A_P_TV, 32'hFFFF_FFF6);
      set_cnt(64'h0000_0000_FFFF_FFF0);
      wr(A_P_TV, 32'h20);
      rd_chk("R7 carry hi", A_P_CHI, 1);
      rd_chk("R7 carry lo", A_P_CLO, 32'h10);
      irq_chk("R7 carry not yet", 3'b000);
      wr(A_P_CTL, 0);
   endtask

   task automatic t_virtual;
      wr(A_O_LO, 32'h100);
      wr(A_O_HI, 0);
      rd_chk("R9 offset lo", A_O_LO, 32'h100);
      rd_chk("R9 offset hi", A_O_HI, 0);
      set_cnt(64'h1000);
      wr(A_V_TV, 32'h10);
      rd_chk("R9 virtual relative lo", A_V_CLO, 32'hF10);
      rd_chk("R9 virtual relative hi", A_V_CHI, 0);
      rd_chk("R9 virtual remaining", A_V_TV, 32'h10);
      wr(A_V_CTL, 1);
      set_cnt(64'h100F);
      irq_chk("R9 virtual one short", 3'b000);
      set_cnt(64'h1010);
      irq_chk("R9 virtual fires on offset count", 3'b100);
      rd_chk("R9 virtual status", A_V_CTL, 32'h5);
      wr(A_V_CTL, 0);
   endtask

   task automatic t_indep;
      wr(A_H_CHI, 0);
      wr(A_H_CLO, 32'h50);
      rd_chk("R10 phys lo untouched", A_P_CLO, 32'h10);
      rd_chk("R10 phys hi untouched", A_P_CHI, 1);
      rd_chk("R10 virt lo untouched", A_V_CLO, 32'hF10);
      wr(A_H_CTL, 1);
      irq_chk("R10 only hyp fires", 3'b010);
      rd_chk("R10 phys ctl untouched", A_P_CTL, 0);
      rd_chk("R10 virt ctl untouched", A_V_CTL, 0);
      wr(A_H_CTL, 0);
      irq_chk("R10 hyp off", 3'b000);
   endtask

   task automatic t_unmapped;
      wr(A_BAD, 32'hDEAD_BEEF);
      rd_chk("R11 high slot reads 0", A_BAD, 0);
      wr(A_O_R0, 32'h7);
      wr(A_O_R3, 32'h1234);
      rd_chk("R11 offset reg0 reads 0", A_O_R0, 0);
      rd_chk("R11 offset reg3 reads 0", A_O_R3, 0);
      rd_chk("R11 offset kept", A_O_LO, 32'h100);
      rd_chk("R11 phys lo kept", A_P_CLO, 32'h10);
      rd_chk("R11 phys ctl kept", A_P_CTL, 0);
      rd_chk("R11 hyp ctl kept", A_H_CTL, 0);
      irq_chk("R11 no irq", 3'b000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #2;
      t_reset();
      t_ctl_fields();
      t_compare();
      t_gating();
      t_wide();
      t_tval();
      t_virtual();
      t_indep();
      t_unmapped();
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule